// File: doc/BRIEF.md
# Indirect Memory Access Port with Auto-Increment

This block gives a host register bus a narrow window into two local memories: a data memory and an instruction memory. The host never addresses the memories directly. It loads a control register with a starting word address and a pair of stepping options, then moves 32-bit words one at a time through a data register. The port advances its own address counter as the words pass.

The instruction memory is organised in 256-byte blocks of 64 words. Each block carries a host-written label (a tag) and a secure flag. The secure flag is taken from the control register whenever a word of that block is written. When a transfer ends part-way through a block, the host can ask the port to pad the rest of that block with zeros.

After reset, each memory is cleared one word per cycle, and a status register shows which clears are still running. A read-only configuration register gives both memory sizes in blocks. An access that falls past the end of a memory is dropped and sets a sticky error bit.

Top module: `ind_mem_port`

## Requirements
- R1: After reset, status register (offset 6) bit 0 (data clear) and bit 1 (instruction clear) read 1. Each memory is cleared one word per cycle, and its bit returns to 0 once every word has been cleared. Every word then reads 0.
- R2: The configuration register (offset 5, read-only) returns the data-memory size in blocks in bits [15:0] and the instruction-memory size in blocks in bits [31:16].
- R3: The data control register is at offset 0 and the instruction control register at offset 2. Each holds a byte address in bits [BLK_W+7:2]: the block index sits in bits [BLK_W+7:8] and the word offset in bits [7:2]. Bit 24 enables stepping on writes, bit 25 enables stepping on reads, and bit 26 is the secure flag. A read of either register returns the live address.
- R4: A write to a data register (offset 1 for data, 3 for instruction) stores the word at the current address. The address advances by one word only when bit 24 is set. After N stepping writes, the address field equals the start address plus 4·N, wrapping within the field.
- R5: A read strobe on a data register returns the addressed word in the cycle after the strobe. The address advances by one word only when bit 25 is set.
- R6: A data-register access at a word address at or beyond the memory size reads 0 and writes nothing, but still steps the address if stepping is enabled. It sets status bit 3, which stays set until the host writes 1 to status bit 3.
- R7: A write to the tag register (offset 4) sets the tag of the instruction block that holds the current instruction address. A read of the tag register returns that block's tag in bits [TAG_W-1:0] and its stored secure flag in bit 31.
- R8: Every instruction-memory word write, whether from the host or from padding, copies control bit 26 into the secure flag of the block being written.
- R9: Writing 1 to status bit 4 while the instruction word offset is non-zero starts padding. The port writes zeros from the current address to the end of the block, one word per cycle, and status bit 2 reads 1 meanwhile. The address ends at the start of the next block. At offset 0 the request has no effect. Writes to the instruction control register are dropped while padding runs.
- R10: While a memory is being cleared, or while the instruction memory is being padded, accesses to that memory's data register are dropped: they write nothing, do not step the address, and read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |

## Verification
Several properties are checked on every cycle. Address stepping on data writes must be exactly one word. An out-of-range access must never reach the memory, must set the error bit and must read back zero. A clear that is in progress must freeze the address. A clear must end only at the last word, and padding must end only on a block boundary. Other behaviours can only be shown by the bench's scenarios, because they depend on what the memories hold. These are the content of full-memory sweeps, per-block tags and secure flags, zeros landing in a padded tail over earlier data, and words that alias an out-of-range address staying untouched.

// File: rtl/imp_pkg.sv
// Package: shared constants and types for the indirect memory port.
// Assumes block size of 64 words and control fields below bit 24.
package imp_pkg;
    localparam int OFS_W     = 6;            // word offset width inside a block
    localparam int BLK_WORDS = 1 << OFS_W;   // words per 256-byte block
    localparam int BIT_INCW  = 24;
    localparam int BIT_INCR  = 25;
    localparam int BIT_SEC   = 26;
    localparam int ST_DCLR   = 0;
    localparam int ST_ICLR   = 1;
    localparam int ST_PAD    = 2;
    localparam int ST_ERR    = 3;
    localparam int ST_PADGO  = 4;

    typedef enum logic [2:0] {
        RA_DCTL  = 3'd0,
        RA_DDATA = 3'd1,
        RA_ICTL  = 3'd2,
        RA_IDATA = 3'd3,
        RA_ITAG  = 3'd4,
        RA_CFG   = 3'd5,
        RA_STAT  = 3'd6,
        RA_NONE  = 3'd7
    } reg_sel_e;

    typedef enum logic [1:0] {
        SRC_REG  = 2'd0,
        SRC_DMEM = 2'd1,
        SRC_IMEM = 2'd2
    } rd_src_e;
endpackage

// File: rtl/imp_scrubber.sv
// Module: post-reset memory clearing sequencer.
// Walks every word address once, one per cycle, starting when reset is
// released; busy stays high until the last address has been issued.
module imp_scrubber #(
    parameter int DEPTH = 256,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic          busy,
    output logic [AW-1:0] addr
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic          busy_q;
    logic [AW-1:0] cnt_q;

    // Advance the clear pointer until the final word is reached.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
        end else if (busy_q) begin
            if (cnt_q == LAST) busy_q <= 1'b0;
            else               cnt_q  <= cnt_q + 1'b1;
        end
    end

    assign busy = busy_q;
    assign addr = cnt_q;

    assert_clear_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_q) |-> $past(cnt_q) == LAST);
endmodule

// File: rtl/imp_mem.sv
// Module: single-port 32-bit word memory, synchronous write and read.
// Read data updates only on a read enable and holds otherwise.
module imp_mem #(
    parameter int DEPTH = 256,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic          re,
    input  logic [AW-1:0] addr,
    input  logic [31:0]   wdata,
    output logic [31:0]   rdata
);
    logic [31:0] arr [DEPTH];

    // One access per cycle: write and/or registered read at addr.
    always_ff @(posedge clk) begin
        if (we) arr[addr] <= wdata;
        if (re) rdata     <= arr[addr];
    end
endmodule

// File: rtl/imp_addr_ctl.sv
// Module: control register and auto-stepping word address counter.
// Assumes the caller never asserts ctl_we and adv for conflicting reasons;
// a control write wins over a step in the same cycle.
module imp_addr_ctl #(
    parameter int WA_W = 14
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ctl_we,
    input  logic [WA_W-1:0] ctl_addr,
    input  logic            ctl_incw,
    input  logic            ctl_incr,
    input  logic            ctl_sec,
    input  logic            adv,
    output logic [WA_W-1:0] waddr,
    output logic            incw,
    output logic            incr,
    output logic            sec
);
    // Load the control fields, or step the address by one word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            waddr <= '0;
            incw  <= 1'b0;
            incr  <= 1'b0;
            sec   <= 1'b0;
        end else if (ctl_we) begin
            waddr <= ctl_addr;
            incw  <= ctl_incw;
            incr  <= ctl_incr;
            sec   <= ctl_sec;
        end else if (adv) begin
            waddr <= waddr + 1'b1;
        end
    end
endmodule

// File: rtl/ind_mem_port.sv
// Module: indirect host access port for a data memory and an instruction
// memory. Decodes the register bus, routes clearing, padding and host
// traffic to the one port of each memory, keeps per-block tags and secure
// flags, and returns read data one cycle after the strobe.
// Assumes one register access per cycle, BLK_W <= 16, TAG_W <= 31 and
// memory sizes below 2**BLK_W blocks.
module ind_mem_port #(
    parameter int DMEM_BLOCKS = 4,
    parameter int IMEM_BLOCKS = 2,
    parameter int BLK_W       = 8,
    parameter int TAG_W       = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata
);
    import imp_pkg::*;

    localparam int WA_W    = BLK_W + OFS_W;
    localparam int D_DEPTH = DMEM_BLOCKS * BLK_WORDS;
    localparam int I_DEPTH = IMEM_BLOCKS * BLK_WORDS;
    localparam int D_AW    = $clog2(D_DEPTH);
    localparam int I_AW    = $clog2(I_DEPTH);
    localparam int I_BW    = (IMEM_BLOCKS > 1) ? $clog2(IMEM_BLOCKS) : 1;

    reg_sel_e sel;
    assign sel = reg_sel_e'(reg_addr);

    // ---------------- clearing sequencers ----------------
    logic            d_clr_busy, i_clr_busy;
    logic [D_AW-1:0] d_clr_addr;
    logic [I_AW-1:0] i_clr_addr;

    imp_scrubber #(.DEPTH(D_DEPTH), .AW(D_AW)) u_dclr (
        .clk(clk), .rst_n(rst_n), .busy(d_clr_busy), .addr(d_clr_addr));
    imp_scrubber #(.DEPTH(I_DEPTH), .AW(I_AW)) u_iclr (
        .clk(clk), .rst_n(rst_n), .busy(i_clr_busy), .addr(i_clr_addr));

    // ---------------- address counters ----------------
    logic            pad_busy;
    logic [WA_W-1:0] d_waddr, i_waddr;
    logic            d_incw, d_incr, d_sec, i_incw, i_incr, i_sec;
    logic            d_ctl_we, i_ctl_we, d_adv, i_adv;

    assign d_ctl_we = reg_wr && (sel == RA_DCTL);
    assign i_ctl_we = reg_wr && (sel == RA_ICTL) && !pad_busy;

    imp_addr_ctl #(.WA_W(WA_W)) u_dctl (
        .clk(clk), .rst_n(rst_n), .ctl_we(d_ctl_we),
        .ctl_addr(reg_wdata[WA_W+1:2]), .ctl_incw(reg_wdata[BIT_INCW]),
        .ctl_incr(reg_wdata[BIT_INCR]), .ctl_sec(reg_wdata[BIT_SEC]),
        .adv(d_adv), .waddr(d_waddr), .incw(d_incw), .incr(d_incr), .sec(d_sec));
    imp_addr_ctl #(.WA_W(WA_W)) u_ictl (
        .clk(clk), .rst_n(rst_n), .ctl_we(i_ctl_we),
        .ctl_addr(reg_wdata[WA_W+1:2]), .ctl_incw(reg_wdata[BIT_INCW]),
        .ctl_incr(reg_wdata[BIT_INCR]), .ctl_sec(reg_wdata[BIT_SEC]),
        .adv(i_adv), .waddr(i_waddr), .incw(i_incw), .incr(i_incr), .sec(i_sec));

    // ---------------- host access qualification ----------------
    logic d_wr, d_rd, i_wr, i_rd, d_hw, d_hr, i_hw, i_hr, i_block;
    logic d_inr, i_inr;

    assign d_wr    = reg_wr && (sel == RA_DDATA);
    assign d_rd    = reg_rd && (sel == RA_DDATA);
    assign i_wr    = reg_wr && (sel == RA_IDATA);
    assign i_rd    = reg_rd && (sel == RA_IDATA);
    assign i_block = i_clr_busy || pad_busy;
    assign d_hw    = d_wr && !d_clr_busy;
    assign d_hr    = d_rd && !d_clr_busy;
    assign i_hw    = i_wr && !i_block;
    assign i_hr    = i_rd && !i_block;
    assign d_inr   = {1'b0, d_waddr} < (WA_W+1)'(D_DEPTH);
    assign i_inr   = {1'b0, i_waddr} < (WA_W+1)'(I_DEPTH);
    assign d_adv   = (d_hw && d_incw) || (d_hr && d_incr);
    assign i_adv   = pad_busy || (i_hw && i_incw) || (i_hr && i_incr);

    // ---------------- tail padding ----------------
    logic pad_go;
    assign pad_go = reg_wr && (sel == RA_STAT) && reg_wdata[ST_PADGO] &&
                    !i_clr_busy && !pad_busy && (i_waddr[OFS_W-1:0] != '0);

    // Run the zero-fill until the last word of the current block.
    always_ff @(posedge clk) begin
        if (!rst_n)                                         pad_busy <= 1'b0;
        else if (pad_go)                                    pad_busy <= 1'b1;
        else if (pad_busy && (i_waddr[OFS_W-1:0] == '1))    pad_busy <= 1'b0;
    end

    // ---------------- memory port muxes ----------------
    logic            dm_we, dm_re, im_we, im_re, im_data_we;
    logic [D_AW-1:0] dm_addr;
    logic [I_AW-1:0] im_addr;
    logic [31:0]     dm_wdata, im_wdata, dm_rdata, im_rdata;

    assign dm_we    = d_clr_busy || (d_hw && d_inr);
    assign dm_re    = d_hr && d_inr;
    assign dm_addr  = d_clr_busy ? d_clr_addr : d_waddr[D_AW-1:0];
    assign dm_wdata = d_clr_busy ? '0 : reg_wdata;

    assign im_data_we = (pad_busy || i_hw) && i_inr;
    assign im_we    = i_clr_busy || im_data_we;
    assign im_re    = i_hr && i_inr;
    assign im_addr  = i_clr_busy ? i_clr_addr : i_waddr[I_AW-1:0];
    assign im_wdata = (i_clr_busy || pad_busy) ? '0 : reg_wdata;

    imp_mem #(.DEPTH(D_DEPTH), .AW(D_AW)) u_dmem (
        .clk(clk), .we(dm_we), .re(dm_re), .addr(dm_addr),
        .wdata(dm_wdata), .rdata(dm_rdata));
    imp_mem #(.DEPTH(I_DEPTH), .AW(I_AW)) u_imem (
        .clk(clk), .we(im_we), .re(im_re), .addr(im_addr),
        .wdata(im_wdata), .rdata(im_rdata));

    // ---------------- per-block tags and secure flags ----------------
    logic [I_BW-1:0]  i_blk;
    logic             tag_we;
    logic [TAG_W-1:0] tag_arr [IMEM_BLOCKS];
    logic             sec_arr [IMEM_BLOCKS];

    assign i_blk  = i_waddr[OFS_W +: I_BW];
    assign tag_we = reg_wr && (sel == RA_ITAG) && i_inr;

    for (genvar b = 0; b < IMEM_BLOCKS; b++) begin : g_blk
        logic [TAG_W-1:0] tag_r;
        logic             sec_r;
        // Hold this block's tag and the secure flag of its latest write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tag_r <= '0;
                sec_r <= 1'b0;
            end else begin
                if (tag_we && (i_blk == I_BW'(b)))     tag_r <= reg_wdata[TAG_W-1:0];
                if (im_data_we && (i_blk == I_BW'(b))) sec_r <= i_sec;
            end
        end
        assign tag_arr[b] = tag_r;
        assign sec_arr[b] = sec_r;
    end

    // ---------------- sticky range error ----------------
    logic err_q, err_set;
    assign err_set = ((d_hw || d_hr) && !d_inr) || ((i_hw || i_hr) && !i_inr);

    // Set on any dropped out-of-range access; host clears by writing 1.
    always_ff @(posedge clk) begin
        if (!rst_n)       err_q <= 1'b0;
        else if (err_set) err_q <= 1'b1;
        else if (reg_wr && (sel == RA_STAT) && reg_wdata[ST_ERR]) err_q <= 1'b0;
    end

    // ---------------- register read path ----------------
    function automatic logic [31:0] ctl_word(input logic [WA_W-1:0] a,
                                             input logic w, input logic r,
                                             input logic s);
        logic [31:0] v;
        v = '0;
        v[WA_W+1:2] = a;
        v[BIT_INCW] = w;
        v[BIT_INCR] = r;
        v[BIT_SEC]  = s;
        return v;
    endfunction

    logic [31:0] tag_val, stat_val, cfg_val;

    // Tag view of the block under the instruction address.
    always_comb begin
        tag_val = '0;
        if (i_inr) begin
            tag_val[TAG_W-1:0] = tag_arr[i_blk];
            tag_val[31]        = sec_arr[i_blk];
        end
    end

    // Status and configuration words.
    always_comb begin
        stat_val          = '0;
        stat_val[ST_DCLR] = d_clr_busy;
        stat_val[ST_ICLR] = i_clr_busy;
        stat_val[ST_PAD]  = pad_busy;
        stat_val[ST_ERR]  = err_q;
        cfg_val           = {16'(IMEM_BLOCKS), 16'(DMEM_BLOCKS)};
    end

    rd_src_e     src_q;
    logic [31:0] rreg_q;

    // Capture the source of a read so data appears the following cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q  <= SRC_REG;
            rreg_q <= '0;
        end else if (reg_rd) begin
            src_q  <= SRC_REG;
            rreg_q <= '0;
            case (sel)
                RA_DCTL:  rreg_q <= ctl_word(d_waddr, d_incw, d_incr, d_sec);
                RA_ICTL:  rreg_q <= ctl_word(i_waddr, i_incw, i_incr, i_sec);
                RA_DDATA: if (dm_re) src_q <= SRC_DMEM;
                RA_IDATA: if (im_re) src_q <= SRC_IMEM;
                RA_ITAG:  rreg_q <= tag_val;
                RA_CFG:   rreg_q <= cfg_val;
                RA_STAT:  rreg_q <= stat_val;
                default:  rreg_q <= '0;
            endcase
        end
    end

    // Select registered register value or the memory output.
    always_comb begin
        case (src_q)
            SRC_DMEM: reg_rdata = dm_rdata;
            SRC_IMEM: reg_rdata = im_rdata;
            default:  reg_rdata = rreg_q;
        endcase
    end

    // ---------------- assertions ----------------
    assert_step_one_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (d_wr && !d_clr_busy && d_incw) |=> d_waddr == $past(d_waddr) + 1'b1);

    assert_oor_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (d_wr && !d_clr_busy && !d_inr) |-> !dm_we);

    assert_oor_sets_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (i_wr && !i_block && !i_inr) |=> err_q);

    assert_oor_reads_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (d_rd && !d_clr_busy && !d_inr) |=> reg_rdata == 32'd0);

    assert_pad_ends_on_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pad_busy) |-> i_waddr[OFS_W-1:0] == '0);

    assert_clear_freezes_addr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (d_clr_busy && d_wr) |=> d_waddr == $past(d_waddr));
endmodule

// File: tb/tb_ind_mem_port.sv
module tb_ind_mem_port;
    localparam int DB = 4;
    localparam int IB = 2;
    localparam int DW = DB * 64;
    localparam int IW = IB * 64;
    localparam logic [31:0] INCW = 32'h0100_0000;
    localparam logic [31:0] INCR = 32'h0200_0000;
    localparam logic [31:0] SEC  = 32'h0400_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ind_mem_port #(.DMEM_BLOCKS(DB), .IMEM_BLOCKS(IB), .BLK_W(8), .TAG_W(16)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

    function automatic logic [31:0] dpat(input int i);
        return 32'(i + 1) * 32'h9E37_79B9;
    endfunction
    function automatic logic [31:0] ipat(input int i);
        return (32'(i) * 32'd7 + 32'd3) | 32'hC000_0000;
    endfunction
    function automatic logic [31:0] waddr(input int w);
        return 32'(w) << 2;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // Called at a negedge; returns at the next negedge.
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int n;
        idle(4);
        rst_n = 1'b1;

        // R1: both clears busy right after reset
        rd(3'd6, v); chk("R1 clear busy at start", v, 32'h3);
        // R10: data access while clearing is dropped, address frozen
        wr(3'd0, INCW);
        wr(3'd1, 32'h1234_5678);
        rd(3'd0, v); chk("R10 no step while clearing", v, INCW);
        // R2: configuration sizes
        rd(3'd5, v); chk("R2 sizes", v, {16'(IB), 16'(DB)});
        idle(140);
        rd(3'd6, v); chk("R1 instruction clear done first", v, 32'h1);
        idle(130);
        rd(3'd6, v); chk("R1 both clears done", v, 32'h0);

        // R1/R5: whole data memory reads zero after clearing
        wr(3'd0, INCR);
        n = 0;
        for (int i = 0; i < DW; i++) begin
            rd(3'd1, v);
            if (v !== 32'h0) n++;
        end
        chk("R1 data memory zero count", 32'(n), 32'h0);
        rd(3'd0, v); chk("R5 read stepping address", v, INCR | waddr(DW));
        wr(3'd2, INCR);
        n = 0;
        for (int i = 0; i < IW; i++) begin
            rd(3'd3, v);
            if (v !== 32'h0) n++;
        end
        chk("R1 instruction memory zero count", 32'(n), 32'h0);

        // R4: full write sweep with stepping, then R3 live address
        wr(3'd0, INCW);
        for (int i = 0; i < DW; i++) wr(3'd1, dpat(i));
        rd(3'd0, v); chk("R3 R4 address after N writes", v, INCW | waddr(DW));
        // R5: full read sweep
        wr(3'd0, INCR);
        for (int i = 0; i < DW; i++) begin
            rd(3'd1, v); chk("R5 sweep word", v, dpat(i));
        end

        // R4/R5: no stepping when enables are clear
        wr(3'd0, waddr(5));
        wr(3'd1, 32'hAAAA_0001);
        wr(3'd1, 32'hBBBB_0002);
        rd(3'd0, v); chk("R4 no step without enable", v, waddr(5));
        rd(3'd1, v); chk("R4 last write wins", v, 32'hBBBB_0002);
        rd(3'd1, v); chk("R5 repeat read same word", v, 32'hBBBB_0002);
        rd(3'd0, v); chk("R5 no step without enable", v, waddr(5));
        wr(3'd0, waddr(6));
        rd(3'd1, v); chk("R4 neighbour untouched", v, dpat(6));

        // R6: out-of-range accesses
        rd(3'd6, v); chk("R6 error clear before", v, 32'h0);
        wr(3'd0, INCW | waddr(DW));
        wr(3'd1, 32'hDEAD_BEEF);
        rd(3'd0, v); chk("R6 out-of-range still steps", v, INCW | waddr(DW + 1));
        rd(3'd6, v); chk("R6 sticky error set", v, 32'h8);
        wr(3'd0, waddr(0));
        rd(3'd1, v); chk("R6 aliased word unchanged", v, dpat(0));
        wr(3'd0, waddr(DW));
        rd(3'd1, v); chk("R6 out-of-range reads zero", v, 32'h0);
        rd(3'd6, v); chk("R6 error still set", v, 32'h8);
        wr(3'd6, 32'h8);
        rd(3'd6, v); chk("R6 error cleared", v, 32'h0);

        // R9 setup: dirty block 1
        wr(3'd2, INCW | waddr(64));
        for (int i = 0; i < 64; i++) wr(3'd3, 32'hFFFF_FFFF);
        // R7/R8: block 0 secure with tag 0x100
        wr(3'd2, SEC | INCW);
        wr(3'd4, 32'h100);
        for (int i = 0; i < 64; i++) wr(3'd3, ipat(i));
        // block 1 non-secure, tag 0x101, partial fill
        wr(3'd2, INCW | waddr(64));
        wr(3'd4, 32'h101);
        for (int i = 64; i < 74; i++) wr(3'd3, ipat(i));
        wr(3'd6, 32'h10);
        wr(3'd3, 32'h0000_0077);     // R10: dropped during padding
        rd(3'd6, v); chk("R9 padding busy", v, 32'h4);
        n = 0;
        do begin
            rd(3'd6, v);
            n++;
        end while (v[2] && n < 200);
        chk("R9 padding finished", v, 32'h0);
        rd(3'd2, v); chk("R9 R10 address at next block", v, INCW | waddr(128));
        wr(3'd2, INCR);
        for (int i = 0; i < IW; i++) begin
            rd(3'd3, v);
            chk("R9 instruction content", v, (i < 74) ? ipat(i) : 32'h0);
        end
        wr(3'd2, waddr(0));
        rd(3'd4, v); chk("R7 R8 block 0 tag and secure", v, 32'h8000_0100);
        wr(3'd2, waddr(70));
        rd(3'd4, v); chk("R7 R8 block 1 tag and secure", v, 32'h0000_0101);

        // R9: request at offset 0 has no effect
        wr(3'd2, INCW | waddr(64));
        wr(3'd6, 32'h10);
        rd(3'd6, v); chk("R9 no padding at offset 0", v, 32'h0);
        rd(3'd2, v); chk("R9 address unchanged", v, INCW | waddr(64));

        // R6: instruction out-of-range read
        wr(3'd2, INCR | waddr(IW));
        rd(3'd3, v); chk("R6 instruction out-of-range reads zero", v, 32'h0);
        rd(3'd2, v); chk("R6 instruction address stepped", v, INCR | waddr(IW + 1));
        rd(3'd6, v); chk("R6 instruction error set", v, 32'h8);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule